// File: doc/BRIEF.md
# Standby Wakeup Clock Controller

This block governs a low-power standby state in which the core clock is gated off. The block runs on an always-on clock. While the core runs, a sleep request moves it into standby, where the core clock enable drops and a two-bit status output tells the board that the input clock may be paused or retuned.

In standby the block watches four kinds of wake source: a non-maskable interrupt, a level-coded interrupt bus, a permitted subset of the external IRQ lines, and GPIO interrupts. No interrupt-block flag is applied. A qualifying event does not reopen the clock at once. It latches a source code and starts a settling counter whose length software set beforehand. When the count runs out, the clock enable returns. The block then gives a one-cycle strobe that asks for interrupt exception entry.

A power-on reset or a manual reset leaves standby at once, with no settling count.

Top module: `stby_wake_ctrl`

## Requirements
- R1: After `rst`, the outputs are: `status`=00, `core_clk_en`=1, `int_req`=0, `evt_code`=0. The settle limit returns to `SETTLE_DEF` (15).
- R2: In the run state, `sleep_req` sampled high makes `status` read 01 (bit 1 low, bit 0 high) and `core_clk_en` read 0 after that clock edge.
- R3: In standby, IRQ lines outside `IRQ_WAKE_MASK` (bits 4 and 5 by default, so IRQ6, IRQ7 and IRQ0 to IRQ3 are excluded) do not wake the block. It stays in standby with `status`=01.
- R4: In standby, any of these wakes the block into settling: `nmi`, a nonzero `irl`, `irq[4]`, `irq[5]`, or any `gpio_irq` bit. While settling, `status` stays 01 and `core_clk_en` stays 0.
- R5: Settling lasts exactly limit+1 cycles after the wake edge. Then `status`=00, `core_clk_en`=1 and `int_req`=1 for exactly one cycle, after which the block is back in run.
- R6: `evt_code` is latched on the wake edge and held until the next wake. The codes are:
  - NMI = 0x01
  - level-coded interrupt = 0x10 | level
  - IRQ line n = 0x20 | n
  - GPIO bit n = 0x40 | n

  When several sources are active, priority is NMI, then the level-coded interrupt, then IRQ, then GPIO. Within IRQ and within GPIO, the lowest index wins.
- R7: Wake events during settling are ignored. `evt_code` and the settling length do not change.
- R8: `cfg_we` loads `cfg_limit` into the settle limit only in the run state. Writes in any other state are ignored.
- R9: `man_rst` in any state returns the block to run after the next edge (`status`=00, `core_clk_en`=1, `int_req`=0) with no strobe. The settle limit is kept.
- R10: Wake inputs seen in the run state change no output. This includes `evt_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| man_rst | input | 1 | Synchronous manual reset, active high; keeps the settle limit |
| sleep_req | input | 1 | Request to enter standby |
| cfg_we | input | 1 | Write strobe for the settle limit |
| cfg_limit | input | CNT_W | Settle limit value |
| nmi | input | 1 | Non-maskable interrupt |
| irl | input | IRL_W | Level-coded interrupt, 0 = none |
| irq | input | IRQ_N | External IRQ lines |
| gpio_irq | input | GPIO_N | GPIO interrupt lines |
| core_clk_en | output | 1 | Core clock enable |
| status | output | 2 | Power state: 00 run, 01 standby or settling |
| int_req | output | 1 | One-cycle interrupt exception entry strobe |
| evt_code | output | 8 | Latched wake source code |

## Verification
The hardest state to reach from the ports is a settling interval that is disturbed partway through. Examples are a second wake source arriving mid-count, a limit write attempted after standby was entered, or a manual reset cutting the count short. To reach these, the bench programs a limit in run, enters standby, and wakes on a low-priority GPIO source. It then injects the disturbance at a known cycle offset and counts cycles to the strobe. An interrupted sequence is followed by a full one, which shows that the kept limit still governs the count.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_STANDBY, ST_SETTLE, ST_RESUME} pm_state_t;

  localparam logic [7:0] CODE_NMI       = 8'h01;
  localparam logic [7:0] CODE_IRL_BASE  = 8'h10;
  localparam logic [7:0] CODE_IRQ_BASE  = 8'h20;
  localparam logic [7:0] CODE_GPIO_BASE = 8'h40;

  localparam logic [1:0] STAT_RUN   = 2'b00;
  localparam logic [1:0] STAT_SLEEP = 2'b01;
endpackage

// File: rtl/wake_qual.sv
module wake_qual #(
  parameter int IRL_W = 4,
  parameter int IRQ_N = 8,
  parameter logic [IRQ_N-1:0] IRQ_WAKE_MASK = 8'h30,
  parameter int GPIO_N = 4
) (
  input  logic              nmi,
  input  logic [IRL_W-1:0]  irl,
  input  logic [IRQ_N-1:0]  irq,
  input  logic [GPIO_N-1:0] gpio_irq,
  output logic              hit,
  output logic [7:0]        code
);
  import stby_pkg::*;

  // Later assignments override earlier ones, so the lowest priority is written first.
  always_comb begin
    hit  = 1'b0;
    code = '0;
    for (int g = GPIO_N - 1; g >= 0; g--) begin
      if (gpio_irq[g]) begin
        hit  = 1'b1;
        code = CODE_GPIO_BASE | 8'(g);
      end
    end
    for (int q = IRQ_N - 1; q >= 0; q--) begin
      if (irq[q] && IRQ_WAKE_MASK[q]) begin
        hit  = 1'b1;
        code = CODE_IRQ_BASE | 8'(q);
      end
    end
    if (irl != '0) begin
      hit  = 1'b1;
      code = CODE_IRL_BASE | 8'(irl);
    end
    if (nmi) begin
      hit  = 1'b1;
      code = CODE_NMI;
    end
  end
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  assign done = run && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= '0;
    end else if (run && !done) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R5: the count never passes the limit while settling.
  a_r5_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= limit));
endmodule

// File: rtl/stby_wake_ctrl.sv
module stby_wake_ctrl #(
  parameter int CNT_W = 8,
  parameter int IRL_W = 4,
  parameter int IRQ_N = 8,
  parameter logic [IRQ_N-1:0] IRQ_WAKE_MASK = 8'h30,
  parameter int GPIO_N = 4,
  parameter int SETTLE_DEF = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              man_rst,
  input  logic              sleep_req,
  input  logic              cfg_we,
  input  logic [CNT_W-1:0]  cfg_limit,
  input  logic              nmi,
  input  logic [IRL_W-1:0]  irl,
  input  logic [IRQ_N-1:0]  irq,
  input  logic [GPIO_N-1:0] gpio_irq,
  output logic              core_clk_en,
  output logic [1:0]        status,
  output logic              int_req,
  output logic [7:0]        evt_code
);
  import stby_pkg::*;

  localparam logic [CNT_W-1:0] LIMIT_RST = CNT_W'(SETTLE_DEF);

  pm_state_t        state_q, state_n;
  logic [CNT_W-1:0] limit_q;
  logic             wake_hit, settle_done, timer_rst, timer_start;
  logic [7:0]       wake_code;

  wake_qual #(
    .IRL_W(IRL_W), .IRQ_N(IRQ_N), .IRQ_WAKE_MASK(IRQ_WAKE_MASK), .GPIO_N(GPIO_N)
  ) u_qual (
    .nmi(nmi), .irl(irl), .irq(irq), .gpio_irq(gpio_irq),
    .hit(wake_hit), .code(wake_code)
  );

  assign timer_rst   = rst || man_rst;
  assign timer_start = (state_q == ST_STANDBY) && wake_hit;

  settle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(timer_rst), .start(timer_start),
    .run(state_q == ST_SETTLE), .limit(limit_q), .done(settle_done)
  );

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_RUN:     if (sleep_req)   state_n = ST_STANDBY;
      ST_STANDBY: if (wake_hit)    state_n = ST_SETTLE;
      ST_SETTLE:  if (settle_done) state_n = ST_RESUME;
      ST_RESUME:                   state_n = ST_RUN;
      default:                     state_n = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || man_rst) begin
      state_q     <= ST_RUN;
      status      <= STAT_RUN;
      core_clk_en <= 1'b1;
      int_req     <= 1'b0;
    end else begin
      state_q     <= state_n;
      status      <= (state_n == ST_STANDBY || state_n == ST_SETTLE) ? STAT_SLEEP : STAT_RUN;
      core_clk_en <= (state_n == ST_RUN || state_n == ST_RESUME);
      int_req     <= (state_n == ST_RESUME);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      limit_q  <= LIMIT_RST;
      evt_code <= '0;
    end else begin
      if (cfg_we && state_q == ST_RUN && !man_rst) limit_q <= cfg_limit;
      if (timer_start && !man_rst) evt_code <= wake_code;
    end
  end

  // R2: a sleep request in run gates the clock after one edge.
  a_r2_enter_standby: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && sleep_req && !man_rst) |=> (status == STAT_SLEEP && !core_clk_en));

  // R5: the exception strobe is a single cycle wide.
  a_r5_strobe_single: assert property (@(posedge clk) disable iff (rst)
    int_req |=> !int_req);

  // R6: a qualified wake always carries a nonzero source code.
  a_r6_code_nonzero: assert property (@(posedge clk) disable iff (rst)
    wake_hit |-> (wake_code != 8'h00));

  // R7: the code is held through settling.
  a_r7_code_hold: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SETTLE) |=> $stable(evt_code));

  // R8: the limit cannot change outside run.
  a_r8_limit_hold: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_RUN) |=> $stable(limit_q));

  // R9: a manual reset lands in run with no strobe.
  a_r9_man_reset: assert property (@(posedge clk) disable iff (rst)
    man_rst |=> (status == STAT_RUN && core_clk_en && !int_req));
endmodule

// File: tb/test_stby_wake_ctrl.sv
module test_stby_wake_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1, man_rst = 1'b0, sleep_req = 1'b0, cfg_we = 1'b0;
  logic [7:0] cfg_limit = '0;
  logic       nmi = 1'b0;
  logic [3:0] irl = '0;
  logic [7:0] irq = '0;
  logic [3:0] gpio_irq = '0;
  logic       core_clk_en, int_req;
  logic [1:0] status;
  logic [7:0] evt_code;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  stby_wake_ctrl i_stby_wake_ctrl (
    .clk(clk), .rst(rst), .man_rst(man_rst), .sleep_req(sleep_req),
    .cfg_we(cfg_we), .cfg_limit(cfg_limit), .nmi(nmi), .irl(irl), .irq(irq),
    .gpio_irq(gpio_irq), .core_clk_en(core_clk_en), .status(status),
    .int_req(int_req), .evt_code(evt_code)
  );

  // Vector fields: nmi, irl[3:0], irq[7:0], gpio[3:0], expected code (00 = must not wake).
  localparam logic [24:0] VEC [11] = '{
    {1'b1, 4'h0, 8'h00, 4'h0, 8'h01},
    {1'b0, 4'h5, 8'h00, 4'h0, 8'h15},
    {1'b0, 4'h0, 8'h10, 4'h0, 8'h24},
    {1'b0, 4'h0, 8'h20, 4'h0, 8'h25},
    {1'b0, 4'h0, 8'h00, 4'h4, 8'h42},
    {1'b1, 4'h3, 8'h10, 4'h1, 8'h01},
    {1'b0, 4'h2, 8'h30, 4'h0, 8'h12},
    {1'b0, 4'h0, 8'h30, 4'h1, 8'h24},
    {1'b0, 4'h0, 8'hC0, 4'h0, 8'h00},
    {1'b0, 4'h0, 8'h0F, 4'h0, 8'h00},
    {1'b0, 4'h0, 8'h80, 4'h8, 8'h43}
  };

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_wake(input logic n, input [3:0] l, input [7:0] q, input [3:0] g);
    nmi = n; irl = l; irq = q; gpio_irq = g;
  endtask

  task automatic program_limit(input [7:0] lim);
    cfg_limit = lim; cfg_we = 1'b1; cyc(); cfg_we = 1'b0;
  endtask

  task automatic enter_standby();
    sleep_req = 1'b1; cyc(); sleep_req = 1'b0;
    chk(status == 2'b01, "R2 status", status, 1);
    chk(core_clk_en == 1'b0, "R2 clk_en", core_clk_en, 0);
  endtask

  // Called right after the wake edge; checks the settle length and the strobe.
  task automatic finish_settle(input int lim, input string req);
    repeat (lim) cyc();
    chk(status == 2'b01 && !core_clk_en, {req, " still settling"}, {status, core_clk_en}, 2);
    cyc();
    chk(int_req && status == 2'b00 && core_clk_en, {req, " resume strobe"},
        {int_req, status, core_clk_en}, 5'b1001);
    cyc();
    chk(!int_req && status == 2'b00, {req, " strobe one cycle"}, int_req, 0);
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(status == 2'b00 && core_clk_en && !int_req && evt_code == 0, "R1 reset state",
        {status, core_clk_en, int_req, evt_code}, 12'h200);

    // Vector walk: R3, R4, R5, R6.
    for (int i = 0; i < 11; i++) begin
      logic [7:0] exp;
      exp = VEC[i][7:0];
      program_limit(8'(i % 4));
      enter_standby();
      set_wake(VEC[i][24], VEC[i][23:20], VEC[i][19:12], VEC[i][11:8]);
      cyc();
      set_wake(1'b0, 4'h0, 8'h00, 4'h0);
      if (exp == 8'h00) begin
        cyc(); cyc();
        chk(status == 2'b01 && !core_clk_en && !int_req, "R3 masked irq no wake",
            {status, core_clk_en}, 2);
        nmi = 1'b1; cyc(); nmi = 1'b0;
        exp = 8'h01;
      end
      chk(status == 2'b01 && !core_clk_en, "R4 settling gated", {status, core_clk_en}, 2);
      chk(evt_code == exp, "R6 event code", evt_code, exp);
      finish_settle(i % 4, "R5");
    end

    // R10: wake inputs in run change nothing.
    set_wake(1'b1, 4'h3, 8'hFF, 4'hF); cyc(); cyc();
    set_wake(1'b0, 4'h0, 8'h00, 4'h0);
    chk(status == 2'b00 && core_clk_en && !int_req, "R10 run outputs",
        {status, core_clk_en, int_req}, 3'b010);
    chk(evt_code == 8'h43, "R10 code kept", evt_code, 8'h43);

    // R8: limit write during standby ignored.
    program_limit(8'd2);
    enter_standby();
    cfg_limit = 8'd9; cfg_we = 1'b1; cyc(); cfg_we = 1'b0;
    gpio_irq = 4'h1; cyc(); gpio_irq = 4'h0;
    chk(evt_code == 8'h40, "R8 code", evt_code, 8'h40);
    finish_settle(2, "R8");

    // R7: NMI during settling is ignored.
    program_limit(8'd4);
    enter_standby();
    gpio_irq = 4'h2; cyc(); gpio_irq = 4'h0;
    cyc();
    nmi = 1'b1; cyc(); cyc(); nmi = 1'b0;
    chk(evt_code == 8'h41, "R7 code unchanged", evt_code, 8'h41);
    cyc();
    chk(status == 2'b01 && !int_req, "R7 still settling", status, 1);
    cyc();
    chk(int_req == 1'b1, "R7 strobe on time", int_req, 1);
    cyc();

    // R9: manual reset mid-settle, then the kept limit governs.
    program_limit(8'd6);
    enter_standby();
    nmi = 1'b1; cyc(); nmi = 1'b0;
    cyc(); cyc();
    man_rst = 1'b1; cyc(); man_rst = 1'b0;
    chk(status == 2'b00 && core_clk_en && !int_req, "R9 man_rst run",
        {status, core_clk_en, int_req}, 3'b010);
    begin
      bit seen = 1'b0;
      for (int k = 0; k < 10; k++) begin
        cyc();
        if (int_req) seen = 1'b1;
      end
      chk(!seen, "R9 no strobe after man_rst", seen, 0);
    end
    enter_standby();
    irq = 8'h20; cyc(); irq = 8'h00;
    chk(evt_code == 8'h25, "R9 code", evt_code, 8'h25);
    finish_settle(6, "R9 kept limit");

    // R9: manual reset in standby.
    enter_standby();
    man_rst = 1'b1; cyc(); man_rst = 1'b0;
    chk(status == 2'b00 && core_clk_en, "R9 man_rst standby", {status, core_clk_en}, 1);

    // R1: power-on reset mid-settle restores the default limit.
    program_limit(8'd3);
    enter_standby();
    irl = 4'h7; cyc(); irl = 4'h0;
    rst = 1'b1; cyc(); rst = 1'b0;
    chk(status == 2'b00 && core_clk_en && !int_req && evt_code == 0, "R1 reset in settle",
        {status, core_clk_en, int_req, evt_code}, 12'h200);
    enter_standby();
    nmi = 1'b1; cyc(); nmi = 1'b0;
    finish_settle(15, "R1 default limit");

    report();
  end
endmodule